// File: doc/BRIEF.md
# Secondary Interrupt Fan-in Controller with Direct Routing

This block collects 32 level-sensitive interrupt sources in front of a primary vectored controller. Every clock it captures the source levels into a raw level register. A software-written enable mask picks which sources take part in one combined request. That request drives the parent output at the highest index, 31. A second register, the direct-route enable, can send sources 21 through 30 straight to the parent output with the same number, so the primary controller sees those sources on their own lines. The block does no vectoring, no arbitration and no edge detection.

Software reaches the block through a word-indexed register bus. A request is a single-cycle strobe, `reg_valid`. The bus has no back-pressure: every strobe is accepted in the cycle it is presented, and the block never stalls a request. A read returns registered data, flagged by `reg_rvalid`, one cycle after the strobe. The mask and the route enables are changed only through set and clear registers, so software never has to read, modify and write them back.

Top module: `sec_irq_router`

## Requirements
- R1: Synchronous reset (`rst` high) clears the raw level, the mask and the route enables. While reset is held and after it is released, `parent_irq`, `reg_rdata` and `reg_rvalid` are 0, and reads of indexes 0, 1, 2 and 8 return 0.
- R2: The raw level register takes the value of `src_in` at every clock edge. Index 1 reads the raw level. A change on `src_in` shows on `parent_irq` one cycle later.
- R3: `parent_irq[31]` is the OR of (raw level AND mask). Index 0 reads (raw level AND mask).
- R4: Index 2 reads the mask. A write to index 2 ORs the data into the mask. A write to index 3 clears every mask bit whose data bit is 1.
- R5: Index 4 reads bit 0 of the raw level, with bits 31..1 returned as 0. Any nonzero write to index 4 sets mask bit 0, and a write of 0 there changes nothing. Any nonzero write to index 5 clears mask bit 0, and a write of 0 there changes nothing.
- R6: Index 8 reads the route-enable register. A write to index 8 sets only the route bits in positions 21..30 whose data bit is 1 (data ANDed with 0x7FE00000). A write to index 9 clears every route bit whose data bit is 1.
- R7: For i in 21..30, `parent_irq[i]` is raw level[i] AND route enable[i`]`, so it is driven low while its route bit is clear. `parent_irq[20:0]` is always 0.
- R8: Reads of any index other than 0, 1, 2, 4 and 8 return 0. Writes to any index other than 2, 3, 4, 5, 8 and 9 change no state.
- R9: `reg_rvalid` is 1 exactly one cycle after a read strobe (`reg_valid` high, `reg_write` low), and `reg_rdata` holds the read value in that cycle. In every other cycle both are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| src_in | input | 32 | Level-sensitive interrupt sources |
| reg_valid | input | 1 | Register request strobe, one cycle per request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | 10 | Word index within the 4 KB window (byte offset / 4) |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |
| reg_rvalid | output | 1 | Read data valid, one cycle after a read |
| parent_irq | output | 32 | Outputs to the primary controller; bit 31 is the combined request |

## Verification
The hardest case to reach is a routed output that must drop while its source is still high. To get there, the mask and route registers are set up first. Then a walking-one pattern and an all-ones pattern are placed on the sources, and only after that is a single route bit cleared. Every source position is swept under three settings: mask only, mask with routing, and routing partly cleared. In each case the expected `parent_irq` is worked out arithmetically from the levels applied, so a stale route bit or an out-of-range route bit shows up as a mismatch on one line. The set-only-if-nonzero rule for bit 0 is tested by writing zero and then nonzero data, and each result is read back through the mask register.

// File: rtl/sirq_pkg.sv
package sirq_pkg;
  // Register word indexes; the numbering is software-visible behaviour.
  localparam int IDX_STATUS  = 0;
  localparam int IDX_RAW     = 1;
  localparam int IDX_EN      = 2;
  localparam int IDX_EN_CLR  = 3;
  localparam int IDX_BIT0    = 4;
  localparam int IDX_BIT0CLR = 5;
  localparam int IDX_RT      = 8;
  localparam int IDX_RT_CLR  = 9;

  // Builds a contiguous bit mask covering positions lo..hi.
  function automatic logic [31:0] range_mask(int lo, int hi);
    logic [31:0] m;
    m = '0;
    for (int b = 0; b < 32; b++) begin
      if (b >= lo && b <= hi) m[b] = 1'b1;
    end
    return m;
  endfunction
endpackage

// File: rtl/sirq_level.sv
module sirq_level #(
  parameter int N = 32
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [N-1:0] src_in,
  output logic [N-1:0] level_q
);
  always_ff @(posedge clk) begin
    if (rst) level_q <= '0;
    else     level_q <= src_in;
  end
endmodule

// File: rtl/sirq_regs.sv
module sirq_regs
  import sirq_pkg::*;
#(
  parameter int          N       = 32,
  parameter int          AW      = 10,
  parameter logic [31:0] RT_MASK = 32'h7FE0_0000
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [N-1:0]  req_wdata,
  input  logic [N-1:0]  level,
  output logic [N-1:0]  mask_q,
  output logic [N-1:0]  route_q,
  output logic [N-1:0]  rdata_q,
  output logic          rvalid_q
);
  localparam logic [N-1:0] RT_KEEP = RT_MASK[N-1:0];
  localparam logic [N-1:0] BIT0    = N'(1);

  logic          do_wr;
  logic          do_rd;
  logic [N-1:0]  mask_d;
  logic [N-1:0]  route_d;
  logic [N-1:0]  rd_mux;
  logic          wdata_nz;

  assign do_wr    = req_valid && req_write;
  assign do_rd    = req_valid && !req_write;
  assign wdata_nz = |req_wdata;

  always_comb begin
    mask_d  = mask_q;
    route_d = route_q;
    if (do_wr) begin
      case (req_addr)
        AW'(IDX_EN):      mask_d  = mask_q | req_wdata;
        AW'(IDX_EN_CLR):  mask_d  = mask_q & ~req_wdata;
        AW'(IDX_BIT0):    if (wdata_nz) mask_d = mask_q | BIT0;
        AW'(IDX_BIT0CLR): if (wdata_nz) mask_d = mask_q & ~BIT0;
        AW'(IDX_RT):      route_d = route_q | (req_wdata & RT_KEEP);
        AW'(IDX_RT_CLR):  route_d = route_q & ~req_wdata;
        default: ;
      endcase
    end
  end

  always_comb begin
    case (req_addr)
      AW'(IDX_STATUS): rd_mux = level & mask_q;
      AW'(IDX_RAW):    rd_mux = level;
      AW'(IDX_EN):     rd_mux = mask_q;
      AW'(IDX_BIT0):   rd_mux = level & BIT0;
      AW'(IDX_RT):     rd_mux = route_q;
      default:         rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mask_q   <= '0;
      route_q  <= '0;
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      mask_q   <= mask_d;
      route_q  <= route_d;
      rvalid_q <= do_rd;
      rdata_q  <= do_rd ? rd_mux : '0;
    end
  end
endmodule

// File: rtl/sirq_route.sv
module sirq_route #(
  parameter int N        = 32,
  parameter int COMB_IDX = 31,
  parameter int RT_LO    = 21,
  parameter int RT_HI    = 30
) (
  input  logic [N-1:0] level,
  input  logic [N-1:0] mask,
  input  logic [N-1:0] route,
  output logic [N-1:0] parent
);
  logic combined;
  assign combined = |(level & mask);

  for (genvar g = 0; g < N; g++) begin : g_out
    if (g == COMB_IDX) begin : g_comb
      assign parent[g] = combined;
    end else if (g >= RT_LO && g <= RT_HI) begin : g_direct
      assign parent[g] = level[g] & route[g];
    end else begin : g_idle
      assign parent[g] = 1'b0;
    end
  end
endmodule

// File: rtl/sec_irq_router.sv
module sec_irq_router
  import sirq_pkg::*;
#(
  parameter int N_SRC    = 32,
  parameter int ADDR_W   = 10,
  parameter int RT_LO    = 21,
  parameter int RT_HI    = 30,
  parameter int COMB_IDX = N_SRC - 1
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [N_SRC-1:0]  src_in,
  input  logic              reg_valid,
  input  logic              reg_write,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [N_SRC-1:0]  reg_wdata,
  output logic [N_SRC-1:0]  reg_rdata,
  output logic              reg_rvalid,
  output logic [N_SRC-1:0]  parent_irq
);
  localparam logic [31:0] RT_MASK = range_mask(RT_LO, RT_HI);

  logic [N_SRC-1:0] level_q;
  logic [N_SRC-1:0] mask_q;
  logic [N_SRC-1:0] route_q;

  sirq_level #(.N(N_SRC)) u_level (
    .clk     (clk),
    .rst     (rst),
    .src_in  (src_in),
    .level_q (level_q)
  );

  sirq_regs #(.N(N_SRC), .AW(ADDR_W), .RT_MASK(RT_MASK)) u_regs (
    .clk       (clk),
    .rst       (rst),
    .req_valid (reg_valid),
    .req_write (reg_write),
    .req_addr  (reg_addr),
    .req_wdata (reg_wdata),
    .level     (level_q),
    .mask_q    (mask_q),
    .route_q   (route_q),
    .rdata_q   (reg_rdata),
    .rvalid_q  (reg_rvalid)
  );

  sirq_route #(.N(N_SRC), .COMB_IDX(COMB_IDX), .RT_LO(RT_LO), .RT_HI(RT_HI)) u_route (
    .level  (level_q),
    .mask   (mask_q),
    .route  (route_q),
    .parent (parent_irq)
  );
endmodule

// File: rtl/sirq_chk.sv
module sirq_chk (
  input logic        clk,
  input logic        rst,
  input logic [31:0] src_in,
  input logic        reg_valid,
  input logic        reg_write,
  input logic [9:0]  reg_addr,
  input logic [31:0] reg_rdata,
  input logic        reg_rvalid,
  input logic [31:0] parent_irq
);
  logic rd_undef;
  assign rd_undef = reg_valid && !reg_write &&
                    !(reg_addr inside {10'd0, 10'd1, 10'd2, 10'd4, 10'd8});

  // R1
  reset_quiet_chk: assert property (@(posedge clk)
    $past(rst) |-> (parent_irq == 32'h0 && reg_rvalid == 1'b0 && reg_rdata == 32'h0));

  // R7
  low_lines_idle_chk: assert property (@(posedge clk) disable iff (rst)
    parent_irq[20:0] == 21'h0);

  // R7
  direct_needs_src_chk: assert property (@(posedge clk) disable iff (rst)
    (parent_irq[30:21] & ~$past(src_in[30:21])) == 10'h0);

  // R3
  combined_needs_src_chk: assert property (@(posedge clk) disable iff (rst)
    parent_irq[31] |-> ($past(src_in) != 32'h0));

  // R9
  rvalid_timing_chk: assert property (@(posedge clk) disable iff (rst)
    reg_rvalid == $past(reg_valid && !reg_write));

  // R9
  rdata_idle_chk: assert property (@(posedge clk) disable iff (rst)
    !reg_rvalid |-> reg_rdata == 32'h0);

  // R8
  undef_read_zero_chk: assert property (@(posedge clk) disable iff (rst)
    $past(rd_undef) |-> reg_rdata == 32'h0);
endmodule

bind sec_irq_router sirq_chk u_chk (
  .clk        (clk),
  .rst        (rst),
  .src_in     (src_in),
  .reg_valid  (reg_valid),
  .reg_write  (reg_write),
  .reg_addr   (reg_addr),
  .reg_rdata  (reg_rdata),
  .reg_rvalid (reg_rvalid),
  .parent_irq (parent_irq)
);

// File: tb/sec_irq_router_bench.sv
module sec_irq_router_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [31:0] src_in = '0;
  logic        reg_valid = 1'b0;
  logic        reg_write = 1'b0;
  logic [9:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        reg_rvalid;
  logic [31:0] parent_irq;

  int n_chk = 0;
  int n_fail = 0;
  logic [31:0] m_mask = '0;
  logic [31:0] m_rt = '0;
  logic [31:0] rv;

  always #4 clk = ~clk;

  sec_irq_router u_sec_irq_router (
    .clk(clk), .rst(rst), .src_in(src_in),
    .reg_valid(reg_valid), .reg_write(reg_write), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
    .parent_irq(parent_irq)
  );

  task automatic chk(string req, logic [31:0] got, logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %08h expected %08h", req, got, exp);
    end
  endtask

  function automatic logic [31:0] exp_par(logic [31:0] l, logic [31:0] m, logic [31:0] r);
    logic [31:0] p;
    p = l & r & 32'h7FE0_0000;
    p[31] = |(l & m);
    return p;
  endfunction

  task automatic wr(int idx, logic [31:0] d);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b1; reg_addr = 10'(idx); reg_wdata = d;
    @(negedge clk);
    reg_valid = 1'b0; reg_write = 1'b0;
    chk("R9 no rvalid after write", {31'h0, reg_rvalid}, 32'h0);
  endtask

  task automatic rd(int idx, output logic [31:0] v);
    @(negedge clk);
    reg_valid = 1'b1; reg_write = 1'b0; reg_addr = 10'(idx);
    @(negedge clk);
    reg_valid = 1'b0;
    chk("R9 rvalid after read", {31'h0, reg_rvalid}, 32'h1);
    v = reg_rdata;
  endtask

  task automatic put_src(logic [31:0] s);
    @(negedge clk);
    src_in = s;
    @(negedge clk);
  endtask

  task automatic sweep(string req);
    for (int i = 0; i < 32; i++) begin
      logic [31:0] s;
      s = 32'h1 << i;
      put_src(s);
      chk(req, parent_irq, exp_par(s, m_mask, m_rt));
    end
    put_src(32'hFFFF_FFFF);
    chk(req, parent_irq, exp_par(32'hFFFF_FFFF, m_mask, m_rt));
  endtask

  initial begin : watchdog
    repeat (50000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    repeat (3) @(negedge clk);
    // R1 reset state, while held
    chk("R1 parent in reset", parent_irq, 32'h0);
    chk("R1 rdata in reset", reg_rdata, 32'h0);
    @(negedge clk); rst = 1'b0;
    chk("R1 parent after reset", parent_irq, 32'h0);
    rd(0, rv); chk("R1 status", rv, 0);
    rd(1, rv); chk("R1 raw", rv, 0);
    rd(2, rv); chk("R1 mask", rv, 0);
    rd(8, rv); chk("R1 route", rv, 0);

    // R2 raw level follows sources, one cycle to outputs
    for (int i = 0; i < 32; i++) begin
      put_src(32'h1 << i);
      chk("R2 parent with mask clear", parent_irq, 32'h0);
      rd(1, rv); chk("R2 raw read", rv, 32'h1 << i);
    end
    put_src(32'h5A5A_C3C3);
    rd(1, rv); chk("R2 raw pattern", rv, 32'h5A5A_C3C3);

    // R4 mask set/clear
    wr(2, 32'hA5A5_0F0E); m_mask = 32'hA5A5_0F0E;
    rd(2, rv); chk("R4 mask set", rv, m_mask);
    wr(2, 32'h0000_F000); m_mask |= 32'h0000_F000;
    rd(2, rv); chk("R4 mask set accumulates", rv, m_mask);
    wr(3, 32'h0000_0F00); m_mask &= ~32'h0000_0F00;
    rd(2, rv); chk("R4 mask clear", rv, m_mask);

    // R3 combined request and status
    sweep("R3 combined output");
    put_src(32'h1234_5678);
    rd(0, rv); chk("R3 status read", rv, 32'h1234_5678 & m_mask);

    // R5 bit 0 set/clear only on nonzero data
    wr(4, 32'h0);
    rd(2, rv); chk("R5 zero write to set ignored", rv, m_mask);
    wr(4, 32'h8000_0000); m_mask[0] = 1'b1;
    rd(2, rv); chk("R5 nonzero set", rv, m_mask);
    put_src(32'h1);
    chk("R5 bit0 drives combined", parent_irq, 32'h8000_0000);
    rd(4, rv); chk("R5 bit0 read high", rv, 32'h1);
    put_src(32'hFFFF_FFFE);
    rd(4, rv); chk("R5 bit0 read low", rv, 32'h0);
    wr(5, 32'h0);
    rd(2, rv); chk("R5 zero write to clear ignored", rv, m_mask);
    wr(5, 32'h0000_0100); m_mask[0] = 1'b0;
    rd(2, rv); chk("R5 nonzero clear", rv, m_mask);

    // R6 route set limited to 21..30
    wr(8, 32'hFFFF_FFFF); m_rt = 32'h7FE0_0000;
    rd(8, rv); chk("R6 route set range", rv, m_rt);
    sweep("R7 routed outputs");
    wr(9, 32'h0200_0001); m_rt &= ~32'h0200_0001;
    rd(8, rv); chk("R6 route clear", rv, m_rt);
    put_src(32'hFFFF_FFFF);
    chk("R7 cleared route drives low", {31'h0, parent_irq[25]}, 32'h0);
    sweep("R7 partial routing");
    wr(3, 32'hFFFF_FFFF); m_mask = '0;
    sweep("R7 routing without mask");

    // R8 undefined indexes
    wr(2, 32'h0F0F_0F0F); m_mask = 32'h0F0F_0F0F;
    foreach (rv[k]) begin end
    for (int j = 0; j < 6; j++) begin
      int idx;
      idx = (j == 0) ? 6 : (j == 1) ? 7 : (j == 2) ? 10 : (j == 3) ? 11 : (j == 4) ? 100 : 1023;
      wr(idx, 32'hFFFF_FFFF);
      rd(idx, rv); chk("R8 undefined read zero", rv, 32'h0);
      rd(2, rv); chk("R8 mask untouched", rv, m_mask);
      rd(8, rv); chk("R8 route untouched", rv, m_rt);
    end
    rd(3, rv); chk("R8 clear index reads zero", rv, 32'h0);
    rd(9, rv); chk("R8 route clear index reads zero", rv, 32'h0);

    // R9 idle cycle keeps rvalid and rdata low
    @(negedge clk);
    chk("R9 idle rvalid", {31'h0, reg_rvalid}, 32'h0);
    chk("R9 idle rdata", reg_rdata, 32'h0);

    // R1 reset clears state again
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    chk("R1 parent after second reset", parent_irq, 32'h0);
    rd(2, rv); chk("R1 mask after second reset", rv, 0);
    rd(8, rv); chk("R1 route after second reset", rv, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule